// File: doc/BRIEF.md
# Table-Driven Shaped Offset-QPSK Modulator

This block turns a stream of 2-bit symbols into shaped baseband I and Q samples without any multipliers. Each rail keeps a short shift register of its most recent symbol bits. A free-running phase counter selects the sample position inside the current symbol. The concatenation of pulse-shape select, rail history and phase addresses a constant table. That table is computed at elaboration and holds, for every bit pattern and phase, the superposed response of all symbols still inside the pulse span. The filter therefore behaves as a Mealy state machine whose whole output function is one lookup.

The symbol rate is tied to the clock: one symbol is taken every `PHASES` cycles, and one I sample and one Q sample come out every cycle. The Q rail is staggered by half a symbol, which gives the offset-QPSK timing. If the source has nothing ready when a symbol is due, the block raises an underrun flag and inserts an idle symbol so the waveform continues.

Top module: `oqpsk_lut_mod`

## Requirements
- R1: While reset is asserted and until the output becomes valid, `out_valid_o` is 0 and both sample outputs are 0. Reset clears the phase counter to 0 and both histories to all-zero bits.
- R2: `in_ready_o` is high for exactly one cycle out of every `PHASES` (4) cycles, namely when the phase counter is at `PHASES-1`. The first such cycle is the fourth cycle after reset is released.
- R3: On each clock edge the I history shifts in `in_sym_i[0]` when `in_ready_o` is high. The registered `out_i_o` then equals `sum over k=0..SPAN-1 of s_k * tap(shape, k*PHASES + p)`, where bit k is the I bit accepted k symbols ago and p is the phase counter.
- R4: The Q bit `in_sym_i[1]` of the accepted symbol enters the Q history two phases later, on the edge where the phase counter leaves `PHASES/2-1`. `out_q_o` uses the same formula with phase `(p + PHASES/2) mod PHASES`.
- R5: Bit value 0 weights its tap by +1 and bit value 1 weights it by -1.
- R6: `mode_i` selects the pulse. With `STEP`=10 and L=`SPAN*PHASES`, mode 0 is a triangle: `tap(m)=STEP*(m+1)` for m<L/2, else `STEP*(L-m)`. Mode 1 is a one-symbol rectangle: `STEP*L/2` where `m/PHASES == SPAN/2`, else 0.
- R7: `out_valid_o` rises one cycle after the SPAN-th symbol shift into the I history, and it stays high from then on.
- R8: When a symbol is due (`in_ready_o` high) and `in_valid_i` is low, `underrun_o` is high in that cycle and the symbol 2'b00 is shifted in instead.
- R9: Samples are registered: an output reflects the history, phase and mode as they stood before the preceding clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Symbol present |
| in_sym_i | input | 2 | Symbol: bit 0 I rail, bit 1 Q rail |
| in_ready_o | output | 1 | Symbol taken this cycle |
| mode_i | input | 1 | Pulse-shape select |
| underrun_o | output | 1 | Symbol due but none offered |
| out_valid_o | output | 1 | Sample outputs valid |
| out_i_o | output | 10 | Signed I sample |
| out_q_o | output | 10 | Signed Q sample |

## Verification
The hardest state to reach is the alignment between the half-symbol Q stagger and a change of symbol polarity that coincides with an underrun insertion. In that case the pending Q bit has to come from an idle symbol, not from the last real one. Random stimulus drops `in_valid_i` at a controlled rate while the symbols and the mode toggle, so underruns land on every history pattern. Directed runs then hold constant symbol streams, idle gaps and each pulse shape long enough to settle every rail, so the outputs can be compared with hand-computed sums.

// File: rtl/oqpsk_shape_pkg.sv
package oqpsk_shape_pkg;

  // Pulse tap m of the selected shape; span*phases taps in total
  function automatic int shape_tap(int shape, int m, int span, int phases, int step);
    int len;
    len = span * phases;
    if (shape == 0) return (m < len / 2) ? step * (m + 1) : step * (len - m);
    return (m / phases == span / 2) ? step * (len / 2) : 0;
  endfunction

  // Superposed sample for one history pattern; bit k = symbol k periods old
  function automatic int table_entry(int shape, int bits, int ph, int span, int phases,
                                     int step);
    int acc;
    int t;
    acc = 0;
    for (int k = 0; k < span; k++) begin
      t = shape_tap(shape, k * phases + ph, span, phases, step);
      acc = (((bits >> k) & 1) != 0) ? acc - t : acc + t;
    end
    return acc;
  endfunction

endpackage

// File: rtl/rail_hist.sv
module rail_hist #(
  parameter int SPAN = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            shift_i,
  input  logic            bit_i,
  output logic [SPAN-1:0] hist_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hist_o <= '0;
    else if (shift_i) hist_o <= {hist_o[SPAN-2:0], bit_i};
  end
endmodule

// File: rtl/sym_timing.sv
module sym_timing #(
  parameter int SPAN   = 3,
  parameter int PHASES = 4,
  localparam int PH_W  = $clog2(PHASES),
  localparam int CNT_W = $clog2(SPAN + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [PH_W-1:0] ph_o,
  output logic            i_shift_o,
  output logic            q_shift_o,
  output logic            full_o
);
  localparam logic [PH_W-1:0]  PH_LAST = PH_W'(PHASES - 1);
  localparam logic [PH_W-1:0]  PH_MID  = PH_W'(PHASES / 2 - 1);
  localparam logic [CNT_W-1:0] FILL_MAX = CNT_W'(SPAN);

  logic [CNT_W-1:0] fill_q;

  assign i_shift_o = (ph_o == PH_LAST);
  assign q_shift_o = (ph_o == PH_MID);
  assign full_o    = (fill_q == FILL_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_o   <= '0;
      fill_q <= '0;
    end else begin
      ph_o <= i_shift_o ? '0 : ph_o + 1'b1;
      if (i_shift_o && !full_o) fill_q <= fill_q + 1'b1;
    end
  end
endmodule

// File: rtl/shape_rom.sv
module shape_rom
  import oqpsk_shape_pkg::*;
#(
  parameter int SPAN    = 3,
  parameter int PHASES  = 4,
  parameter int SHAPES  = 2,
  parameter int STEP    = 10,
  parameter int SAMP_W  = 10,
  localparam int PH_W   = $clog2(PHASES),
  localparam int MODE_W = $clog2(SHAPES),
  localparam int ADDR_W = MODE_W + SPAN + PH_W,
  localparam int DEPTH  = 2 ** ADDR_W
) (
  input  logic        [ADDR_W-1:0] addr_i,
  output logic signed [SAMP_W-1:0] sample_o
);
  logic signed [SAMP_W-1:0] tbl [DEPTH];

  for (genvar a = 0; a < DEPTH; a++) begin : g_entry
    localparam int SHP = a >> (SPAN + PH_W);
    localparam int BTS = (a >> PH_W) & ((1 << SPAN) - 1);
    localparam int PHS = a & (PHASES - 1);
    assign tbl[a] = SAMP_W'(table_entry(SHP, BTS, PHS, SPAN, PHASES, STEP));
  end

  assign sample_o = tbl[addr_i];
endmodule

// File: rtl/oqpsk_lut_mod.sv
module oqpsk_lut_mod #(
  parameter int SPAN    = 3,
  parameter int PHASES  = 4,
  parameter int SHAPES  = 2,
  parameter int STEP    = 10,
  parameter int SAMP_W  = 10,
  localparam int PH_W   = $clog2(PHASES),
  localparam int MODE_W = $clog2(SHAPES),
  localparam int ADDR_W = MODE_W + SPAN + PH_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     in_valid_i,
  input  logic [1:0]               in_sym_i,
  output logic                     in_ready_o,
  input  logic [MODE_W-1:0]        mode_i,
  output logic                     underrun_o,
  output logic                     out_valid_o,
  output logic signed [SAMP_W-1:0] out_i_o,
  output logic signed [SAMP_W-1:0] out_q_o
);
  logic [PH_W-1:0]          ph, q_ph;
  logic                     i_shift, q_shift, full;
  logic [1:0]               sym_eff;
  logic                     q_pend;
  logic [SPAN-1:0]          hist_i, hist_q;
  logic signed [SAMP_W-1:0] samp_i, samp_q;

  sym_timing #(.SPAN(SPAN), .PHASES(PHASES)) u_timing (
    .clk_i, .rst_ni, .ph_o(ph), .i_shift_o(i_shift), .q_shift_o(q_shift), .full_o(full)
  );

  assign in_ready_o = i_shift;
  assign underrun_o = i_shift && !in_valid_i;
  assign sym_eff    = in_valid_i ? in_sym_i : 2'b00;  // idle symbol on underrun
  assign q_ph       = ph + PH_W'(PHASES / 2);          // half-symbol stagger

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_pend <= 1'b0;
    else if (i_shift) q_pend <= sym_eff[1];
  end

  rail_hist #(.SPAN(SPAN)) u_hist_i (
    .clk_i, .rst_ni, .shift_i(i_shift), .bit_i(sym_eff[0]), .hist_o(hist_i)
  );
  rail_hist #(.SPAN(SPAN)) u_hist_q (
    .clk_i, .rst_ni, .shift_i(q_shift), .bit_i(q_pend), .hist_o(hist_q)
  );

  shape_rom #(.SPAN(SPAN), .PHASES(PHASES), .SHAPES(SHAPES), .STEP(STEP), .SAMP_W(SAMP_W))
    u_rom_i (.addr_i({mode_i, hist_i, ph}), .sample_o(samp_i));
  shape_rom #(.SPAN(SPAN), .PHASES(PHASES), .SHAPES(SHAPES), .STEP(STEP), .SAMP_W(SAMP_W))
    u_rom_q (.addr_i({mode_i, hist_q, q_ph}), .sample_o(samp_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_i_o     <= '0;
      out_q_o     <= '0;
    end else begin
      out_valid_o <= full;
      out_i_o     <= full ? samp_i : '0;
      out_q_o     <= full ? samp_q : '0;
    end
  end
endmodule

// File: rtl/oqpsk_lut_mod_chk.sv
module oqpsk_lut_mod_chk #(
  parameter int SPAN    = 3,
  parameter int SHAPES  = 2,
  parameter int SAMP_W  = 10,
  localparam int MODE_W = $clog2(SHAPES),
  localparam int CNT_W  = $clog2(SPAN + 1)
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     in_valid_i,
  input logic [1:0]               in_sym_i,
  input logic                     in_ready_o,
  input logic [MODE_W-1:0]        mode_i,
  input logic                     underrun_o,
  input logic                     out_valid_o,
  input logic signed [SAMP_W-1:0] out_i_o,
  input logic signed [SAMP_W-1:0] out_q_o
);
  logic [CNT_W-1:0] taken_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) taken_q <= '0;
    else if (in_ready_o && taken_q != CNT_W'(SPAN)) taken_q <= taken_q + 1'b1;
  end

  AST_READY_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o |=> !in_ready_o);  // R2
  AST_VALID_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |=> out_valid_o);  // R7
  AST_NO_EARLY_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (taken_q != CNT_W'(SPAN)) |-> !out_valid_o);  // R7
  AST_UNDERRUN_DUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underrun_o |-> (in_ready_o && !in_valid_i));  // R8
  AST_QUIET_INVALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> (out_i_o == '0 && out_q_o == '0));  // R1
endmodule

bind oqpsk_lut_mod oqpsk_lut_mod_chk #(.SPAN(SPAN), .SHAPES(SHAPES), .SAMP_W(SAMP_W)) u_chk (.*);

// File: tb/oqpsk_lut_mod_tb.sv
module oqpsk_lut_mod_tb;
  localparam int SPAN = 3, PHASES = 4, STEP = 10, SAMP_W = 10;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic in_valid_i = 1'b0;
  logic [1:0] in_sym_i = 2'b00;
  logic [0:0] mode_i = 1'b0;
  logic in_ready_o, underrun_o, out_valid_o;
  logic signed [SAMP_W-1:0] out_i_o, out_q_o;

  int n_vec = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  oqpsk_lut_mod u_dut (.*);

  function automatic int tap(int shape, int m);
    int len = SPAN * PHASES;
    if (shape == 0) return (m < len / 2) ? STEP * (m + 1) : STEP * (len - m);
    return (m / PHASES == SPAN / 2) ? STEP * (len / 2) : 0;
  endfunction

  function automatic int expect_samp(int shape, logic [SPAN-1:0] h, int p);
    int s = 0;
    for (int k = 0; k < SPAN; k++) s += h[k] ? -tap(shape, k * PHASES + p) : tap(shape, k * PHASES + p);
    return s;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // Reference model of the requirements
  int m_ph, m_fill;
  logic [SPAN-1:0] m_hi, m_hq;
  logic m_qp;
  int e_i, e_q, e_v;
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_ph = 0; m_fill = 0; m_hi = '0; m_hq = '0; m_qp = 0; e_i = 0; e_q = 0; e_v = 0;
    end else begin
      e_v = (m_fill == SPAN);
      e_i = e_v ? expect_samp(mode_i, m_hi, m_ph) : 0;
      e_q = e_v ? expect_samp(mode_i, m_hq, (m_ph + PHASES / 2) % PHASES) : 0;
      if (m_ph == PHASES / 2 - 1) m_hq = {m_hq[SPAN-2:0], m_qp};
      if (m_ph == PHASES - 1) begin
        m_hi = {m_hi[SPAN-2:0], in_valid_i ? in_sym_i[0] : 1'b0};
        m_qp = in_valid_i ? in_sym_i[1] : 1'b0;
        if (m_fill < SPAN) m_fill++;
      end
      m_ph = (m_ph + 1) % PHASES;
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      chk("R2 in_ready_o", in_ready_o, m_ph == PHASES - 1);
      chk("R8 underrun_o", underrun_o, (m_ph == PHASES - 1) && !in_valid_i);
      chk("R7 out_valid_o", out_valid_o, e_v);
      chk("R3 R5 R9 out_i_o", out_i_o, e_i);
      chk("R4 R6 out_q_o", out_q_o, e_q);
    end
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected < 100000", cyc);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  task automatic hold(bit v, logic [1:0] s, bit md, int cycles);
    @(posedge clk_i); #1;
    in_valid_i = v; in_sym_i = s; mode_i = md;
    repeat (cycles) @(posedge clk_i);
  endtask

  // Sample the phase-0 I output and matching Q output of a settled symbol
  task automatic settled(string req, int exp_i, int exp_q);
    do @(negedge clk_i); while (!in_ready_o);
    @(posedge clk_i); @(posedge clk_i); @(negedge clk_i);
    chk({req, " settled I"}, out_i_o, exp_i);
    chk({req, " settled Q"}, out_q_o, exp_q);
  endtask

  initial begin
    void'($urandom(32'h5eed_0a11));
    repeat (3) @(negedge clk_i);
    chk("R1 reset valid", out_valid_o, 0);
    chk("R1 reset I", out_i_o, 0);
    chk("R1 reset Q", out_q_o, 0);
    chk("R1 reset ready", in_ready_o, 0);
    @(posedge clk_i); #1 rst_ni = 1'b1;

    // Directed: all-zero bits, triangle: +100 on I phase 0, +110 on Q phase 2
    hold(1, 2'b00, 0, 40);
    settled("R5", 100, 110);
    // all-one bits invert the sums
    hold(1, 2'b11, 0, 40);
    settled("R5", -100, -110);
    // rectangle shape: only the centre symbol contributes STEP*L/2
    hold(1, 2'b00, 1, 40);
    settled("R6", 60, 60);
    hold(1, 2'b11, 1, 40);
    settled("R6", -60, -60);
    // starvation: idle 00 symbols return to the all-positive sums
    hold(0, 2'b11, 0, 40);
    settled("R8", 100, 110);
    // mixed I/Q: I bits 1, Q bits 0
    hold(1, 2'b01, 0, 40);
    settled("R3 R4", -100, 110);

    // Random stimulus with underruns and mode changes
    for (int n = 0; n < 3000; n++) begin
      @(posedge clk_i); #1;
      in_valid_i = ($urandom_range(0, 99) < 80);
      in_sym_i   = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 63) == 0) mode_i = ~mode_i;
    end
    @(negedge clk_i);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule